// File: doc/BRIEF.md
# USB Endpoint Stall Controller

This block holds the stall state of every endpoint of a USB device function and gives, for each host transaction, a verdict: answer with a STALL handshake or accept the transaction. Each endpoint has two layers of state. Application firmware writes a request register with one bit per endpoint. A hidden halt bit sits behind each request bit. The application never writes the halt bit directly. The halt bit is set lazily, when a transaction reaches an endpoint whose request bit is set. After that it can only be dropped by the host, either through a Clear Feature (endpoint halt) event aimed at the endpoint or, for endpoint 0 only, through the arrival of a SETUP transaction.

An optional auto-clear mode removes the request bit at the same moment a stall is raised because of it. After that, one Clear Feature from the host is enough to bring the endpoint back. Without auto-clear, the application has to withdraw its request itself. If it does not, a host Clear Feature only re-arms the stall, which returns on the next transaction. Packet parsing, the PHY, the data buffers and the decoding of standard requests are outside the block. Clear Feature and SETUP reach it as already-decoded single-cycle pulses.

Top module: `ep_stall_ctrl`

## Requirements
- R1: Reset clears every request bit, every halt bit, the auto-clear enable and the verdict valid output. After reset, a transaction to an endpoint that stalled before the reset is accepted.
- R2: A request-register write changes only the bits whose mask bit is 1. Bit i of the request register and of the readback belongs to endpoint i, and the new value is visible on the readback the cycle after the write.
- R3: Writing a request bit does not set the halt bit. If a request bit is set and then withdrawn before any transaction reaches that endpoint, the next transaction to it is accepted.
- R4: A transaction to an endpoint whose halt bit and request bit are both clear is accepted (stall flag 0), and no state changes.
- R5: A transaction to an endpoint whose halt bit is clear and whose request bit is set is stalled and sets the halt bit. From then on, every transaction to that endpoint is stalled, even after the application clears the request bit, until the host clears the halt bit.
- R6: When auto-clear is enabled and a stall is raised because of a request bit, that request bit reads back as 0 the next cycle.
- R7: When auto-clear is disabled, a stall leaves the request bit set.
- R8: A Clear Feature event clears the halt bit of the named endpoint only. If that endpoint's request bit is still set, the next transaction to it stalls again.
- R9: A SETUP event clears the halt bit of endpoint 0 only. A Clear Feature or SETUP event in the same cycle as a transaction takes effect before that transaction is judged.
- R10: When an application write and an auto-clear hit the same request bit in the same cycle, the auto-clear wins and the bit ends up 0.
- R11: The verdict is a valid pulse exactly one cycle long, raised in the cycle after the transaction strobe. It carries the stall flag and repeats the endpoint number of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr_en | input | 1 | Request-register write strobe |
| req_wr_data | input | NUM_EP | Write data, bit i for endpoint i |
| req_wr_mask | input | NUM_EP | Write mask, 1 = update that bit |
| acen_wr_en | input | 1 | Auto-clear enable write strobe |
| acen_wr_data | input | 1 | New auto-clear enable value |
| txn_valid | input | 1 | Host transaction strobe |
| txn_ep | input | EPW | Endpoint number of the transaction (binary) |
| clrfeat_valid | input | 1 | Host Clear Feature (endpoint halt) pulse |
| clrfeat_ep | input | EPW | Endpoint named by the Clear Feature |
| setup_valid | input | 1 | SETUP received on endpoint 0 pulse |
| dec_valid | output | 1 | Verdict valid pulse |
| dec_stall | output | 1 | 1 = answer STALL, 0 = accept |
| dec_ep | output | EPW | Endpoint the verdict refers to |
| req_rd | output | NUM_EP | Request register readback |
| acen_rd | output | 1 | Auto-clear enable readback |

## Verification
The bench targets the cases where the two state layers come apart. One case is a request that is withdrawn before any traffic arrives. A design that sets the halt bit at write time would stall there. Another is a Clear Feature sent while the request bit is still set. A design that clears both layers would accept instead of stalling again. Same-cycle cases are driven too: a Clear Feature or SETUP together with a transaction, where a design that judges before clearing gives a stale stall, and an application write that collides with an auto-clear, where the wrong priority leaves the request set. A SETUP is also sent while a non-zero endpoint is halted, to catch a design that clears too widely.

// File: rtl/ep_stall_pkg.sv
package ep_stall_pkg;
  // Default endpoint count of the device function
  localparam int unsigned EP_COUNT_DEF = 8;

  // Kind of verdict produced for a transaction
  typedef enum logic [1:0] {
    VERD_ACCEPT   = 2'd0,
    VERD_HALTED   = 2'd1,
    VERD_REQUEST  = 2'd2
  } verdict_e;
endpackage

// File: rtl/stall_req_reg.sv
module stall_req_reg #(
  parameter int unsigned NUM_EP = ep_stall_pkg::EP_COUNT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_EP-1:0] wr_data,
  input  logic [NUM_EP-1:0] wr_mask,
  input  logic              acen_wr_en,
  input  logic              acen_wr_data,
  input  logic [NUM_EP-1:0] autoclr_mask,
  output logic [NUM_EP-1:0] req_q,
  output logic              acen_q
);
  // Masked merge of new data into the old register value
  function automatic logic [NUM_EP-1:0] merge_bits(
    input logic [NUM_EP-1:0] old_v,
    input logic [NUM_EP-1:0] new_v,
    input logic [NUM_EP-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  logic [NUM_EP-1:0] written;
  logic [NUM_EP-1:0] req_d;

  always_comb begin
    written = wr_en ? merge_bits(req_q, wr_data, wr_mask) : req_q;
    // auto-clear takes priority over a same-cycle write
    req_d   = written & ~autoclr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      acen_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (acen_wr_en) acen_q <= acen_wr_data;
    end
  end
endmodule

// File: rtl/halt_bank.sv
module halt_bank #(
  parameter int unsigned NUM_EP = ep_stall_pkg::EP_COUNT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] clr_mask,
  input  logic [NUM_EP-1:0] set_mask,
  output logic [NUM_EP-1:0] halt_q
);
  for (genvar g = 0; g < NUM_EP; g++) begin : g_halt
    always_ff @(posedge clk) begin
      if (!rst_n)
        halt_q[g] <= 1'b0;
      else if (set_mask[g])
        halt_q[g] <= 1'b1;
      else if (clr_mask[g])
        halt_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/stall_decide.sv
module stall_decide #(
  parameter int unsigned NUM_EP = ep_stall_pkg::EP_COUNT_DEF,
  localparam int unsigned EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic [EPW-1:0]    txn_ep,
  input  logic [NUM_EP-1:0] halt_q,
  input  logic [NUM_EP-1:0] req_q,
  input  logic [NUM_EP-1:0] clr_mask,
  input  logic              acen,
  output logic [NUM_EP-1:0] set_mask,
  output logic [NUM_EP-1:0] autoclr_mask,
  output logic              ev_req_stall,
  output logic              dec_valid,
  output logic              dec_stall,
  output logic [EPW-1:0]    dec_ep
);
  import ep_stall_pkg::*;

  // Binary endpoint number to one-hot select
  function automatic logic [NUM_EP-1:0] ep_sel(input logic [EPW-1:0] ep);
    logic [NUM_EP-1:0] r;
    r = '0;
    r[ep] = 1'b1;
    return r;
  endfunction

  // Verdict for one endpoint given the live halt bit and request bit
  function automatic verdict_e judge(input logic halt_live, input logic req);
    if (halt_live) return VERD_HALTED;
    if (req)       return VERD_REQUEST;
    return VERD_ACCEPT;
  endfunction

  logic [NUM_EP-1:0] halt_live;
  logic [NUM_EP-1:0] sel;
  verdict_e          verd;

  always_comb begin
    // host clears act before the transaction is judged
    halt_live    = halt_q & ~clr_mask;
    sel          = txn_valid ? ep_sel(txn_ep) : '0;
    verd         = judge(halt_live[txn_ep], req_q[txn_ep]);
    ev_req_stall = txn_valid && (verd == VERD_REQUEST);
    set_mask     = ev_req_stall ? sel : '0;
    autoclr_mask = (ev_req_stall && acen) ? sel : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_stall <= 1'b0;
      dec_ep    <= '0;
    end else begin
      dec_valid <= txn_valid;
      if (txn_valid) begin
        dec_stall <= (verd != VERD_ACCEPT);
        dec_ep    <= txn_ep;
      end
    end
  end
endmodule

// File: rtl/ep_stall_ctrl.sv
module ep_stall_ctrl #(
  parameter int unsigned NUM_EP = ep_stall_pkg::EP_COUNT_DEF,
  localparam int unsigned EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr_en,
  input  logic [NUM_EP-1:0] req_wr_data,
  input  logic [NUM_EP-1:0] req_wr_mask,
  input  logic              acen_wr_en,
  input  logic              acen_wr_data,
  input  logic              txn_valid,
  input  logic [EPW-1:0]    txn_ep,
  input  logic              clrfeat_valid,
  input  logic [EPW-1:0]    clrfeat_ep,
  input  logic              setup_valid,
  output logic              dec_valid,
  output logic              dec_stall,
  output logic [EPW-1:0]    dec_ep,
  output logic [NUM_EP-1:0] req_rd,
  output logic              acen_rd
);
  // Named internal events, also observed by the bound checker
  logic [NUM_EP-1:0] clr_mask;
  logic [NUM_EP-1:0] set_mask;
  logic [NUM_EP-1:0] autoclr_mask;
  logic [NUM_EP-1:0] halt_q;
  logic              ev_req_stall;

  always_comb begin
    clr_mask = '0;
    if (clrfeat_valid) clr_mask[clrfeat_ep] = 1'b1;
    if (setup_valid)   clr_mask[0]          = 1'b1;
  end

  stall_req_reg #(.NUM_EP(NUM_EP)) req_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (req_wr_en),
    .wr_data      (req_wr_data),
    .wr_mask      (req_wr_mask),
    .acen_wr_en   (acen_wr_en),
    .acen_wr_data (acen_wr_data),
    .autoclr_mask (autoclr_mask),
    .req_q        (req_rd),
    .acen_q       (acen_rd)
  );

  halt_bank #(.NUM_EP(NUM_EP)) halt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .halt_q   (halt_q)
  );

  stall_decide #(.NUM_EP(NUM_EP)) dec_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .txn_valid    (txn_valid),
    .txn_ep       (txn_ep),
    .halt_q       (halt_q),
    .req_q        (req_rd),
    .clr_mask     (clr_mask),
    .acen         (acen_rd),
    .set_mask     (set_mask),
    .autoclr_mask (autoclr_mask),
    .ev_req_stall (ev_req_stall),
    .dec_valid    (dec_valid),
    .dec_stall    (dec_stall),
    .dec_ep       (dec_ep)
  );
endmodule

// File: rtl/ep_stall_chk.sv
module ep_stall_chk #(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic [EPW-1:0]    txn_ep,
  input logic              clrfeat_valid,
  input logic [EPW-1:0]    clrfeat_ep,
  input logic              dec_valid,
  input logic              dec_stall,
  input logic [EPW-1:0]    dec_ep,
  input logic [NUM_EP-1:0] req_rd,
  input logic              acen_rd,
  input logic [NUM_EP-1:0] halt_q,
  input logic [NUM_EP-1:0] clr_mask,
  input logic              ev_req_stall
);
  logic [NUM_EP-1:0] live;
  assign live = halt_q & ~clr_mask;

  // R11
  verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> (dec_valid && dec_ep == $past(txn_ep)));

  // R11
  verdict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !dec_valid);

  // R4
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !live[txn_ep] && !req_rd[txn_ep]) |=> !dec_stall);

  // R5
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && (live[txn_ep] || req_rd[txn_ep])) |=> dec_stall);

  // R5
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(live) & ~halt_q) == '0));

  // R6
  autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acen_rd && ev_req_stall) |=> !req_rd[$past(txn_ep)]);

  // R8
  clrfeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrfeat_valid && !(txn_valid && txn_ep == clrfeat_ep)) |=> !halt_q[$past(clrfeat_ep)]);
endmodule

bind ep_stall_ctrl ep_stall_chk #(.NUM_EP(NUM_EP)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .txn_valid     (txn_valid),
  .txn_ep        (txn_ep),
  .clrfeat_valid (clrfeat_valid),
  .clrfeat_ep    (clrfeat_ep),
  .dec_valid     (dec_valid),
  .dec_stall     (dec_stall),
  .dec_ep        (dec_ep),
  .req_rd        (req_rd),
  .acen_rd       (acen_rd),
  .halt_q        (halt_q),
  .clr_mask      (clr_mask),
  .ev_req_stall  (ev_req_stall)
);

// File: tb/ep_stall_ctrl_tb_top.sv
module ep_stall_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_wr_en = 1'b0;
  logic [7:0] req_wr_data = '0;
  logic [7:0] req_wr_mask = '0;
  logic       acen_wr_en = 1'b0;
  logic       acen_wr_data = 1'b0;
  logic       txn_valid = 1'b0;
  logic [2:0] txn_ep = '0;
  logic       clrfeat_valid = 1'b0;
  logic [2:0] clrfeat_ep = '0;
  logic       setup_valid = 1'b0;
  logic       dec_valid, dec_stall, acen_rd;
  logic [2:0] dec_ep;
  logic [7:0] req_rd;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_stall_ctrl #(.NUM_EP(NE)) dut_i (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs sampled just after the capturing edge
  task automatic step(input logic wr, input logic [7:0] d, input logic [7:0] m,
                      input logic tx, input logic [2:0] tep,
                      input logic cf, input logic [2:0] cep, input logic su);
    @(negedge clk);
    req_wr_en = wr; req_wr_data = d; req_wr_mask = m;
    txn_valid = tx; txn_ep = tep;
    clrfeat_valid = cf; clrfeat_ep = cep; setup_valid = su;
    @(posedge clk); #1;
    req_wr_en = 0; txn_valid = 0; clrfeat_valid = 0; setup_valid = 0;
  endtask

  task automatic wr_req(input logic [7:0] d, input logic [7:0] m);
    step(1, d, m, 0, 0, 0, 0, 0);
  endtask
  task automatic txn(input logic [2:0] ep);
    step(0, 0, 0, 1, ep, 0, 0, 0);
  endtask
  task automatic cfeat(input logic [2:0] ep);
    step(0, 0, 0, 0, 0, 1, ep, 0);
  endtask
  task automatic set_acen(input logic v);
    @(negedge clk); acen_wr_en = 1; acen_wr_data = v;
    @(negedge clk); acen_wr_en = 0;
  endtask
  task automatic chk_verdict(input string tag, input logic [2:0] ep, input logic st);
    check({tag, " valid"}, dec_valid, 1);
    check({tag, " ep"}, dec_ep, ep);
    check({tag, " stall"}, dec_stall, st);
  endtask

  // op: 0 write request, 1 transaction, 2 clear feature, 3 setup
  // fields: op[29:28] ep[27:25] data[24:17] mask[16:9] stall[8] req_after[7:0]
  localparam int NV = 23;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 3'd0, 8'h01, 8'hFF, 1'b0, 8'h01},  // R2
    {2'd1, 3'd0, 8'h00, 8'h00, 1'b1, 8'h01},  // R5 R7
    {2'd0, 3'd0, 8'h00, 8'h01, 1'b0, 8'h00},
    {2'd1, 3'd0, 8'h00, 8'h00, 1'b1, 8'h00},  // R5 sticky
    {2'd2, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00},
    {2'd1, 3'd0, 8'h00, 8'h00, 1'b0, 8'h00},  // R4
    {2'd0, 3'd0, 8'h0C, 8'h0C, 1'b0, 8'h0C},
    {2'd1, 3'd2, 8'h00, 8'h00, 1'b1, 8'h0C},  // R7
    {2'd1, 3'd1, 8'h00, 8'h00, 1'b0, 8'h0C},
    {2'd2, 3'd2, 8'h00, 8'h00, 1'b0, 8'h0C},
    {2'd1, 3'd2, 8'h00, 8'h00, 1'b1, 8'h0C},  // R8 re-stall
    {2'd0, 3'd0, 8'h00, 8'h04, 1'b0, 8'h08},
    {2'd2, 3'd2, 8'h00, 8'h00, 1'b0, 8'h08},
    {2'd1, 3'd2, 8'h00, 8'h00, 1'b0, 8'h08},
    {2'd1, 3'd3, 8'h00, 8'h00, 1'b1, 8'h08},
    {2'd3, 3'd0, 8'h00, 8'h00, 1'b0, 8'h08},
    {2'd1, 3'd3, 8'h00, 8'h00, 1'b1, 8'h08},  // R9 setup spares ep3
    {2'd0, 3'd0, 8'h00, 8'h08, 1'b0, 8'h00},
    {2'd1, 3'd3, 8'h00, 8'h00, 1'b1, 8'h00},  // R5
    {2'd2, 3'd3, 8'h00, 8'h00, 1'b0, 8'h00},
    {2'd1, 3'd3, 8'h00, 8'h00, 1'b0, 8'h00},
    {2'd0, 3'd0, 8'hFF, 8'h10, 1'b0, 8'h10},  // R2 mask
    {2'd1, 3'd7, 8'h00, 8'h00, 1'b0, 8'h10}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 req", req_rd, 0);
    check("R1 acen", acen_rd, 0);
    check("R1 valid", dec_valid, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      case (v[29:28])
        2'd0: wr_req(v[24:17], v[16:9]);
        2'd1: txn(v[27:25]);
        2'd2: cfeat(v[27:25]);
        default: step(0, 0, 0, 0, 0, 0, 0, 1);
      endcase
      if (v[29:28] == 2'd1) chk_verdict($sformatf("R5 R7 R8 vec%0d", i), v[27:25], v[8]);
      else check($sformatf("R11 idle vec%0d", i), dec_valid, 0);
      check($sformatf("R2 req vec%0d", i), req_rd, v[7:0]);
    end

    // R6 auto-clear
    set_acen(1);
    check("R6 acen", acen_rd, 1);
    wr_req(8'h20, 8'h20);
    txn(5);  chk_verdict("R6", 5, 1); check("R6 req", req_rd, 8'h10);
    txn(5);  chk_verdict("R5 halted", 5, 1);
    cfeat(5);
    txn(5);  chk_verdict("R8 cleared", 5, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R11 one-cycle", dec_valid, 0);

    // R10 collision of write and auto-clear
    wr_req(8'h40, 8'h40);
    step(1, 8'h40, 8'h40, 1, 6, 0, 0, 0);
    chk_verdict("R10", 6, 1); check("R10 req", req_rd, 8'h10);
    // R9 clear in same cycle as transaction
    step(0, 0, 0, 1, 6, 1, 6, 0);
    chk_verdict("R9 same-cycle cf", 6, 0);

    // R9 setup
    wr_req(8'h01, 8'h01);
    txn(0); chk_verdict("R9 ep0 halt", 0, 1); check("R6 req ep0", req_rd, 8'h10);
    wr_req(8'h02, 8'h02);
    txn(1); chk_verdict("R9 ep1 halt", 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    txn(1); chk_verdict("R9 setup only ep0", 1, 1);
    step(0, 0, 0, 1, 0, 0, 0, 1);
    chk_verdict("R9 same-cycle setup", 0, 0);
    cfeat(1);
    txn(1); chk_verdict("R8 ep1", 1, 0);

    // R3 write does not halt
    wr_req(8'h08, 8'h08);
    wr_req(8'h00, 8'h08);
    txn(3); chk_verdict("R3", 3, 0);

    // R1 reset mid-run clears halts
    txn(4); chk_verdict("R1 pre", 4, 1);
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    check("R1 req", req_rd, 0);
    check("R1 acen", acen_rd, 0);
    check("R1 valid", dec_valid, 0);
    @(negedge clk); rst_n = 1;
    txn(4); chk_verdict("R1 halt cleared", 4, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule